// File: doc/BRIEF.md
# Configurable Logic Element Slice

This block models a small programmable logic cluster. It holds a row of logic cells, eight by default, that share one set of control lines. Each cell has a 16-bit lookup mask addressed by four data inputs, one storage flip-flop, a link to its lower neighbour in a carry chain and a link to its lower neighbour in a cascade chain. Per-cell configuration words choose one of four operating modes. In normal mode the mask is a 4-input function. In arithmetic mode the mask holds two 3-input functions. The two counter modes are up/down and clearable.

Configuration also sets how the register's asynchronous terms behave, whether a shared control line gates the register's clock enable, and whether the cell output shows the table result or the register. The four shared lines each pass through a programmable inverter. Lines 0 and 1 can act as clock enables. Lines 2 and 3 are the clear sources. An active-low chip-wide reset clears every register.

Chaining cells gives ripple adders, multi-bit counters and wide AND decodes. The configuration is treated as static while the cluster runs.

Top module: `lc_cluster`

## Requirements
- R1: While rst_n is low every cell register reads 0 at once, without a clock edge. This holds in every mode and overrides an active asynchronous load of 1.
- R2: In normal mode (cellMode code 0) the cell's table output is mask bit {data4,data3,data2,data1}. Here data(k+1) is dataIn bit 4*i+k of cell i, and mask bit b is lutMask bit 16*i+b. The combinational output is that table output ANDed with the cell's cascade input. The register loads this value on each enabled rising clock edge.
- R3: Cell 0 takes cascadeIn as its cascade input, and each higher cell takes the cascade output of the cell below it. A normal-mode cell drives its combinational output onto the cascade chain. A cell in any other mode passes its cascade input through. cascadeOut is the top cell's cascade output.
- R4: In arithmetic mode (code 1) the result is mask bit {0,cin,data2,data1} and the carry output is mask bit {1,cin,data2,data1}. The register stores the result. Cell 0's carry input is carryIn, each cell feeds the next, and carryOut is the top cell's carry. A normal-mode cell passes carry through unchanged. With mask 16'hE896 in every cell, the cluster adds two 8-bit numbers.
- R5: In up/down counter mode (code 2) the data inputs have these roles:
  - data1 is the count enable.
  - data2 selects the direction: 1 counts up, 0 counts down.
  - data3 is the value to load.
  - data4 is an active-low synchronous load, which takes priority over counting.

  The combinational output is q XOR cin. The carry output is cin AND q when counting up, and cin AND NOT q when counting down. The mask is ignored.
- R6: In clearable counter mode (code 3) data2 is an active-high synchronous clear, with priority over load and count. The cell counts up only, its carry output is cin AND q, and the other inputs keep their R5 roles.
- R7: When enaUse is 0 for a cell, its register is always clock-enabled. When enaUse is 1, the register updates only while the effective shared line chosen by enaSel (0 selects line 0, 1 selects line 1) is 1; otherwise it holds. This applies to loads, counts and synchronous clears alike.
- R8: In async-clear register mode (regCtl code 1) the register is 0 whenever effective line 2 or effective line 3 is 1. The clear takes effect at once and overrides clocked updates. Preset is never active in this mode.
- R9: In async-load register mode (regCtl code 2) the register follows data3 immediately while effective line 2 is 0. Line 3 has no effect in this mode. When line 2 returns to 1, the register keeps the last loaded value until a clocked update. Codes 0 and 3 use no asynchronous term except reset.
- R10: Each effective shared line equals ctlIn XOR ctlInv, bit by bit. Inverting a line swaps its idle and active levels for every use of that line.
- R11: Bit i of cellOut equals regOut bit i when outSel bit i is 1, and combOut bit i when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock |
| rst_n | input | 1 | Chip-wide reset, active low, asynchronous clear |
| lutMask | input | 128 | Lookup masks, 16 bits per cell |
| cellMode | input | 16 | Operating mode, 2 bits per cell |
| regCtl | input | 16 | Register async scheme, 2 bits per cell |
| enaUse | input | 8 | Gate register enable with a shared line |
| enaSel | input | 8 | Choice of shared line 0 or 1 as enable |
| outSel | input | 8 | Cell output source, 1 = register |
| ctlInv | input | 4 | Per-line inversion of the shared controls |
| ctlIn | input | 4 | Shared control lines |
| dataIn | input | 32 | Four data inputs per cell |
| carryIn | input | 1 | Carry into cell 0 |
| cascadeIn | input | 1 | Cascade into cell 0 |
| combOut | output | 8 | Combinational cell outputs |
| regOut | output | 8 | Register outputs |
| cellOut | output | 8 | Selected cell outputs |
| carryOut | output | 1 | Carry from the top cell |
| cascadeOut | output | 1 | Cascade from the top cell |

## Verification
The hardest behaviour to reach from the ports is the asynchronous register terms acting between clock edges. This covers a clear raised mid-cycle, a load that tracks data3 as it changes, and reset overriding a load of 1 that is still active. The bench raises those lines a few time units after an edge and samples the registers before the next edge. It then holds them across an edge and releases them, so level behaviour, holding and recovery are all observed. The chains are exercised by a full 8-bit adder sweep. Two 4-bit counters, whose carry rides through normal-mode cells to carryOut, are run against arithmetic models over long pseudo-random sequences.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LutInputs = 4;
  localparam int MaskW     = 1 << LutInputs;
  localparam int CtlW      = 4;
  // shared control line roles
  localparam int CtlEnaA = 0;
  localparam int CtlEnaB = 1;
  localparam int CtlClrA = 2;
  localparam int CtlClrB = 3;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ARITH  = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_CLRCNT = 2'd3
  } cellMode_e;

  typedef enum logic [1:0] {
    REG_PLAIN = 2'd0,
    REG_ACLR  = 2'd1,
    REG_ALOAD = 2'd2,
    REG_SPARE = 2'd3
  } regCtl_e;

  typedef struct packed {
    logic ena;
    logic aClr;
    logic aSet;
  } cellStrb_t;
endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int NCells = 8
) (
  input  logic                   rst_n,
  input  logic [CtlW-1:0]        ctlIn,
  input  logic [CtlW-1:0]        ctlInv,
  input  logic [2*NCells-1:0]    regCtl,
  input  logic [NCells-1:0]      enaUse,
  input  logic [NCells-1:0]      enaSel,
  input  logic [NCells-1:0]      loadVal,
  output cellStrb_t [NCells-1:0] strb
);
  logic [CtlW-1:0] ctlEff;
  logic            clrAny;
  logic            loadStrobe;

  assign ctlEff     = ctlIn ^ ctlInv;
  assign clrAny     = ctlEff[CtlClrA] | ctlEff[CtlClrB];
  assign loadStrobe = ~ctlEff[CtlClrA];

  for (genvar i = 0; i < NCells; i++) begin : g_strb
    regCtl_e kind;
    logic    isClr;
    logic    isLoad;
    assign kind   = regCtl_e'(regCtl[2*i +: 2]);
    assign isClr  = (kind == REG_ACLR);
    assign isLoad = (kind == REG_ALOAD);

    assign strb[i].ena  = enaUse[i] ? (enaSel[i] ? ctlEff[CtlEnaB] : ctlEff[CtlEnaA]) : 1'b1;
    assign strb[i].aClr = ~rst_n | (isClr & clrAny) | (isLoad & loadStrobe & ~loadVal[i]);
    assign strb[i].aSet = rst_n & isLoad & loadStrobe & loadVal[i];
  end
endmodule

// File: rtl/lc_cell.sv
module lc_cell
  import lc_pkg::*;
(
  input  logic                 clk,
  input  cellMode_e            mode,
  input  logic [MaskW-1:0]     mask,
  input  logic [LutInputs-1:0] din,
  input  logic                 cin,
  input  logic                 casIn,
  input  cellStrb_t            strb,
  output logic                 comb,
  output logic                 q,
  output logic                 cout,
  output logic                 casOut
);
  logic lutFull;
  logic arithSum;
  logic arithCarry;
  logic toggle;
  logic nextQ;
  logic aClr;
  logic aSet;

  assign lutFull    = mask[din];
  assign arithSum   = mask[{1'b0, cin, din[1:0]}];
  assign arithCarry = mask[{1'b1, cin, din[1:0]}];
  assign toggle     = q ^ cin;
  assign aClr       = strb.aClr;
  assign aSet       = strb.aSet;

  always_comb begin
    comb   = lutFull & casIn;
    cout   = cin;
    nextQ  = lutFull & casIn;
    casOut = lutFull & casIn;
    case (mode)
      MODE_ARITH: begin
        comb   = arithSum;
        cout   = arithCarry;
        nextQ  = arithSum;
        casOut = casIn;
      end
      MODE_UPDOWN: begin
        comb   = toggle;
        cout   = cin & (din[1] ? q : ~q);
        nextQ  = !din[3] ? din[2] : (din[0] ? toggle : q);
        casOut = casIn;
      end
      MODE_CLRCNT: begin
        comb   = toggle;
        cout   = cin & q;
        nextQ  = din[1] ? 1'b0 : (!din[3] ? din[2] : (din[0] ? toggle : q));
        casOut = casIn;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or posedge aClr or posedge aSet) begin
    if (aClr)          q <= 1'b0;
    else if (aSet)     q <= 1'b1;
    else if (strb.ena) q <= nextQ;
  end
endmodule

// File: rtl/lc_datapath.sv
module lc_datapath
  import lc_pkg::*;
#(
  parameter int NCells = 8
) (
  input  logic                        clk,
  input  logic [NCells*MaskW-1:0]     lutMask,
  input  logic [2*NCells-1:0]         cellMode,
  input  logic [NCells*LutInputs-1:0] dataIn,
  input  logic [NCells-1:0]           outSel,
  input  cellStrb_t [NCells-1:0]      strb,
  input  logic                        carryIn,
  input  logic                        cascadeIn,
  output logic [NCells-1:0]           combOut,
  output logic [NCells-1:0]           regOut,
  output logic [NCells-1:0]           cellOut,
  output logic                        carryOut,
  output logic                        cascadeOut
);
  logic [NCells:0] carryChain;
  logic [NCells:0] casChain;

  assign carryChain[0] = carryIn;
  assign casChain[0]   = cascadeIn;

  for (genvar i = 0; i < NCells; i++) begin : g_cell
    lc_cell u_cell (
      .clk    (clk),
      .mode   (cellMode_e'(cellMode[2*i +: 2])),
      .mask   (lutMask[i*MaskW +: MaskW]),
      .din    (dataIn[i*LutInputs +: LutInputs]),
      .cin    (carryChain[i]),
      .casIn  (casChain[i]),
      .strb   (strb[i]),
      .comb   (combOut[i]),
      .q      (regOut[i]),
      .cout   (carryChain[i+1]),
      .casOut (casChain[i+1])
    );
  end

  assign carryOut   = carryChain[NCells];
  assign cascadeOut = casChain[NCells];
  assign cellOut    = (regOut & outSel) | (combOut & ~outSel);
endmodule

// File: rtl/lc_cluster.sv
module lc_cluster
  import lc_pkg::*;
#(
  parameter int NCells = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCells*MaskW-1:0]     lutMask,
  input  logic [2*NCells-1:0]         cellMode,
  input  logic [2*NCells-1:0]         regCtl,
  input  logic [NCells-1:0]           enaUse,
  input  logic [NCells-1:0]           enaSel,
  input  logic [NCells-1:0]           outSel,
  input  logic [CtlW-1:0]             ctlInv,
  input  logic [CtlW-1:0]             ctlIn,
  input  logic [NCells*LutInputs-1:0] dataIn,
  input  logic                        carryIn,
  input  logic                        cascadeIn,
  output logic [NCells-1:0]           combOut,
  output logic [NCells-1:0]           regOut,
  output logic [NCells-1:0]           cellOut,
  output logic                        carryOut,
  output logic                        cascadeOut
);
  localparam int LoadBit = 2;  // data3 supplies the async load value

  cellStrb_t [NCells-1:0] strb;
  logic [NCells-1:0]      loadVal;

  for (genvar i = 0; i < NCells; i++) begin : g_load
    assign loadVal[i] = dataIn[i*LutInputs + LoadBit];
  end

  lc_ctrl #(.NCells(NCells)) u_ctrl (
    .rst_n   (rst_n),
    .ctlIn   (ctlIn),
    .ctlInv  (ctlInv),
    .regCtl  (regCtl),
    .enaUse  (enaUse),
    .enaSel  (enaSel),
    .loadVal (loadVal),
    .strb    (strb)
  );

  lc_datapath #(.NCells(NCells)) u_dp (
    .clk        (clk),
    .lutMask    (lutMask),
    .cellMode   (cellMode),
    .dataIn     (dataIn),
    .outSel     (outSel),
    .strb       (strb),
    .carryIn    (carryIn),
    .cascadeIn  (cascadeIn),
    .combOut    (combOut),
    .regOut     (regOut),
    .cellOut    (cellOut),
    .carryOut   (carryOut),
    .cascadeOut (cascadeOut)
  );
endmodule

// File: rtl/lc_cluster_chk.sv
module lc_cluster_chk
  import lc_pkg::*;
#(
  parameter int NCells = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [2*NCells-1:0]         cellMode,
  input logic [2*NCells-1:0]         regCtl,
  input logic [NCells-1:0]           enaUse,
  input logic [NCells-1:0]           enaSel,
  input logic [CtlW-1:0]             ctlInv,
  input logic [CtlW-1:0]             ctlIn,
  input logic [NCells*LutInputs-1:0] dataIn,
  input logic                        cascadeIn,
  input logic [NCells-1:0]           regOut,
  input logic                        cascadeOut
);
  logic [CtlW-1:0]   eff;
  logic [NCells-1:0] isNormal;
  logic [NCells-1:0] asyncIdle;
  logic [NCells-1:0] gatedOff;

  assign eff = ctlIn ^ ctlInv;

  for (genvar i = 0; i < NCells; i++) begin : g_chk
    assign isNormal[i]  = (cellMode[2*i +: 2] == MODE_NORMAL);
    assign asyncIdle[i] = (regCtl[2*i +: 2] == REG_ACLR)  ? !(eff[CtlClrA] || eff[CtlClrB]) :
                          (regCtl[2*i +: 2] == REG_ALOAD) ? eff[CtlClrA] : 1'b1;
    assign gatedOff[i]  = enaUse[i] && !(enaSel[i] ? eff[CtlEnaB] : eff[CtlEnaA]);

    AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((regCtl[2*i +: 2] == REG_ACLR) && (eff[CtlClrA] || eff[CtlClrB])) |-> !regOut[i]); // R8

    AST_ASYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ((regCtl[2*i +: 2] == REG_ALOAD) && !eff[CtlClrA]) |-> (regOut[i] == dataIn[i*LutInputs + 2])); // R9

    AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (gatedOff[i] && asyncIdle[i]) |=> (!asyncIdle[i] || (regOut[i] == $past(regOut[i])))); // R7

    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((cellMode[2*i +: 2] == MODE_CLRCNT) && !gatedOff[i] && dataIn[i*LutInputs + 1] &&
       (regCtl[2*i +: 2] != REG_ALOAD)) |=> !regOut[i]); // R6
  end

  AST_CASCADE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((&isNormal) && !cascadeIn) |-> !cascadeOut); // R3
endmodule

bind lc_cluster lc_cluster_chk #(.NCells(NCells)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cellMode   (cellMode),
  .regCtl     (regCtl),
  .enaUse     (enaUse),
  .enaSel     (enaSel),
  .ctlInv     (ctlInv),
  .ctlIn      (ctlIn),
  .dataIn     (dataIn),
  .cascadeIn  (cascadeIn),
  .regOut     (regOut),
  .cascadeOut (cascadeOut)
);

// File: tb/lc_cluster_tb.sv
module lc_cluster_tb_top;
  localparam int N = 8;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*16-1:0] lutMask;
  logic [2*N-1:0]  cellMode;
  logic [2*N-1:0]  regCtl;
  logic [N-1:0]    enaUse;
  logic [N-1:0]    enaSel;
  logic [N-1:0]    outSel;
  logic [3:0]      ctlInv;
  logic [3:0]      ctlIn;
  logic [4*N-1:0]  dataIn;
  logic            carryIn;
  logic            cascadeIn;
  wire  [N-1:0]    combOut;
  wire  [N-1:0]    regOut;
  wire  [N-1:0]    cellOut;
  wire             carryOut;
  wire             cascadeOut;

  int checks = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'h1234_5679;

  lc_cluster #(.NCells(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .lutMask(lutMask), .cellMode(cellMode), .regCtl(regCtl),
    .enaUse(enaUse), .enaSel(enaSel), .outSel(outSel), .ctlInv(ctlInv), .ctlIn(ctlIn),
    .dataIn(dataIn), .carryIn(carryIn), .cascadeIn(cascadeIn), .combOut(combOut),
    .regOut(regOut), .cellOut(cellOut), .carryOut(carryOut), .cascadeOut(cascadeOut)
  );

  always #(ClkPeriod/2) clk = ~clk;

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic setAllModes(input logic [1:0] m, input logic [1:0] rc);
    for (int i = 0; i < N; i++) begin
      cellMode[2*i +: 2] = m;
      regCtl[2*i +: 2]   = rc;
    end
  endtask

  task automatic setAllMasks(input logic [15:0] m);
    for (int i = 0; i < N; i++) lutMask[16*i +: 16] = m;
  endtask

  // normal-mode reference: each cell's table value ANDed along the cascade
  function automatic logic [N:0] normChain(input logic casStart);
    logic c;
    logic [N:0] r;
    c = casStart;
    for (int i = 0; i < N; i++) begin
      c = lutMask[16*i + int'(dataIn[4*i +: 4])] & c;
      r[i] = c;
    end
    r[N] = c;
    return r;
  endfunction

  initial begin
    repeat (WatchdogCycles) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N:0] expChain;
    logic [3:0] q;
    logic [3:0] tg;
    logic [7:0] expReg;
    logic [7:0] pat;
    logic c;
    logic [31:0] r;
    logic [8:0] sum;

    setAllModes(2'd0, 2'd0);
    setAllMasks(16'hFFFF);
    enaUse = '0; enaSel = '0; outSel = '0; ctlInv = '0; ctlIn = '0;
    dataIn = '0; carryIn = 1'b0; cascadeIn = 1'b1;

    // R1: reset holds every register clear
    repeat (3) step();
    check("R1 reset state", regOut, 8'h00);
    rst_n = 1'b1;
    step();
    check("R2 register loads table", regOut, 8'hFF);

    // R2/R3: one cell under test at a time, others all-ones
    for (int k = 0; k < N; k++) begin
      setAllMasks(16'hFFFF);
      lutMask[16*k +: 16] = rnd();
      for (int v = 0; v < 16; v++) begin
        for (int j = 0; j < N; j++) dataIn[4*j +: 4] = 4'(v + 3*j);
        cascadeIn = 1'b1;
        #1;
        expChain = normChain(1'b1);
        check("R2 single table", combOut, expChain[N-1:0]);
        check("R3 cascade out", cascadeOut, expChain[N]);
        cascadeIn = 1'b0;
        #1;
        check("R3 cascade blocked", {cascadeOut, combOut}, 9'h000);
      end
    end
    cascadeIn = 1'b1;
    for (int it = 0; it < 64; it++) begin
      for (int j = 0; j < N; j++) lutMask[16*j +: 16] = 16'(rnd()) | 16'(rnd());
      dataIn = rnd();
      #1;
      expChain = normChain(1'b1);
      check("R2 R3 random chain", combOut, expChain[N-1:0]);
      check("R3 random cascade out", cascadeOut, expChain[N]);
    end
    step();
    check("R2 registered chain", regOut, expChain[N-1:0]);

    // R4: exhaustive 8-bit adder
    setAllModes(2'd1, 2'd0);
    setAllMasks(16'hE896);
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int ci = 0; ci < 2; ci++) begin
          dataIn = '0;
          for (int i = 0; i < N; i++) begin
            dataIn[4*i]   = a[i];
            dataIn[4*i+1] = b[i];
          end
          carryIn = ci[0];
          #1;
          sum = 9'(a + b + ci);
          check("R4 adder sum", combOut, sum[7:0]);
          check("R4 adder carry", carryOut, sum[8]);
        end
      end
    end
    step();
    dataIn = '0;
    for (int i = 0; i < N; i++) begin
      dataIn[4*i]   = 1'(8'h9C >> i);
      dataIn[4*i+1] = 1'(8'h77 >> i);
    end
    carryIn = 1'b1;
    step();
    sum = 9'h9C + 9'h77 + 9'h1;
    check("R4 adder registered", regOut, sum[7:0]);

    // R5: 4-bit up/down counter in cells 0..3, carry rides through normal cells
    for (int i = 0; i < N; i++) begin
      cellMode[2*i +: 2] = (i < 4) ? 2'd2 : 2'd0;
      lutMask[16*i +: 16] = rnd();
    end
    carryIn = 1'b1;
    dataIn = '0;
    rst_n = 1'b0; #1; rst_n = 1'b1;
    q = 4'h0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      logic en, up, nload;
      logic [3:0] ldv;
      r = rnd();
      en = r[0]; up = r[1]; nload = |r[4:2]; ldv = r[11:8];
      for (int i = 0; i < 4; i++) dataIn[4*i +: 4] = {nload, ldv[i], up, en};
      #1;
      c = 1'b1;
      for (int i = 0; i < 4; i++) begin
        tg[i] = q[i] ^ c;
        c = c & (up ? q[i] : ~q[i]);
      end
      check("R5 toggle outputs", combOut[3:0], tg);
      check("R5 terminal carry", carryOut, c);
      step();
      if (!nload) q = ldv;
      else if (en) q = up ? q + 4'd1 : q - 4'd1;
      check("R5 count value", regOut[3:0], q);
    end

    // R6: clearable counter
    for (int i = 0; i < 4; i++) cellMode[2*i +: 2] = 2'd3;
    for (int cyc = 0; cyc < 300; cyc++) begin
      logic en, sclr, nload;
      logic [3:0] ldv;
      r = rnd();
      en = r[0]; sclr = (r[3:1] == 3'd0); nload = |r[6:4]; ldv = r[11:8];
      for (int i = 0; i < 4; i++) dataIn[4*i +: 4] = {nload, ldv[i], sclr, en};
      #1;
      c = 1'b1;
      for (int i = 0; i < 4; i++) begin
        tg[i] = q[i] ^ c;
        c = c & q[i];
      end
      check("R6 toggle outputs", combOut[3:0], tg);
      check("R6 terminal carry", carryOut, c);
      step();
      if (sclr) q = 4'h0;
      else if (!nload) q = ldv;
      else if (en) q = q + 4'd1;
      check("R6 count value", regOut[3:0], q);
    end

    // R7/R10: shared enables, line 1 inverted
    setAllModes(2'd0, 2'd0);
    setAllMasks(16'hFFFF);
    cascadeIn = 1'b1;
    dataIn = '0;
    step();
    expReg = 8'hFF;
    check("R7 ungated load", regOut, expReg);
    enaUse = 8'hFF; enaSel = 8'hAA; ctlInv = 4'b0010;
    for (int it = 0; it < 16; it++) begin
      logic tgt;
      r = rnd();
      ctlIn[1:0] = r[1:0];
      tgt = r[2];
      setAllMasks({16{tgt}});
      step();
      for (int i = 0; i < N; i++)
        if (enaSel[i] ? ~ctlIn[1] : ctlIn[0]) expReg[i] = tgt;
      check("R7 R10 gated enable", regOut, expReg);
    end

    // R8/R10: async clear
    enaUse = '0; ctlInv = '0; ctlIn = '0;
    setAllModes(2'd0, 2'd1);
    setAllMasks(16'hFFFF);
    step();
    check("R8 idle clear lines", regOut, 8'hFF);
    #3; ctlIn[3] = 1'b1; #1;
    check("R8 clear between edges", regOut, 8'h00);
    step();
    check("R8 clear held over edge", regOut, 8'h00);
    ctlIn[3] = 1'b0;
    step();
    check("R8 recovery", regOut, 8'hFF);
    ctlInv[2] = 1'b1; ctlIn[2] = 1'b1;
    step();
    check("R10 inverted line idle", regOut, 8'hFF);
    #3; ctlIn[2] = 1'b0; #1;
    check("R10 inverted line clears", regOut, 8'h00);
    step();
    ctlIn[2] = 1'b1;
    step();
    check("R10 recovery", regOut, 8'hFF);

    // R9: async load
    ctlInv = '0; ctlIn = 4'b0100;
    enaUse = 8'hFF; enaSel = '0;
    setAllModes(2'd0, 2'd2);
    setAllMasks(16'h0000);
    pat = 8'hB2;
    dataIn = '0;
    for (int i = 0; i < N; i++) dataIn[4*i+2] = pat[i];
    step();
    check("R7 R9 hold with load idle", regOut, 8'hFF);
    #3; ctlIn[2] = 1'b0; #1;
    check("R9 load between edges", regOut, pat);
    step();
    check("R9 load held over edge", regOut, pat);
    pat = 8'h4D;
    for (int i = 0; i < N; i++) dataIn[4*i+2] = pat[i];
    #1;
    check("R9 load follows data3", regOut, pat);
    step();
    ctlIn[2] = 1'b1;
    step();
    check("R9 value kept after load", regOut, pat);
    ctlIn[3] = 1'b1;
    #1;
    check("R9 line 3 ignored", regOut, pat);
    step();
    check("R9 line 3 ignored over edge", regOut, pat);
    ctlIn[3] = 1'b0;

    // R1: reset beats an active load of ones
    ctlIn[2] = 1'b0; #1;
    check("R9 reload", regOut, pat);
    rst_n = 1'b0; #1;
    check("R1 reset over load", regOut, 8'h00);
    step();
    check("R1 reset held", regOut, 8'h00);
    rst_n = 1'b1; #1;
    check("R9 load after reset", regOut, pat);
    step();
    ctlIn[2] = 1'b1;
    step();

    // R11: output select
    enaUse = '0; ctlIn = '0;
    setAllModes(2'd0, 2'd0);
    setAllMasks(16'hFFFF);
    step();
    setAllMasks(16'h0000);
    outSel = 8'h5A;
    #1;
    check("R11 mixed select", cellOut, 8'h5A);
    outSel = 8'hA5;
    #1;
    check("R11 swapped select", cellOut, 8'hA5);
    outSel = 8'h00;
    #1;
    check("R11 all table", cellOut, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule